// File: doc/BRIEF.md
# SDRAM Command Issuer Triggered by Bus Writes

This block sits between a processor bus and the command port of an SDRAM controller. Software loads a three-bit MODE value into a register. While MODE is zero, the memory window behaves normally: every read or write presented to it is forwarded as a data access one clock later. While MODE holds a command code, a write to the memory window moves no data. The write acts as a trigger instead. It is converted into one SDRAM command of the kind MODE selects. The bank address of that command is taken from upper bits of the write address, and the mode-register payload is taken from its lower bits.

The position of the bank field depends on the configured bus width. With a 16-bit bus the bank field starts at address bit 25. With a 32-bit bus it starts one bit higher. The payload field is shifted in the same way.

After a command is issued, a fixed gap follows. During the gap the block accepts no further trigger, and the ready output shows when a new trigger can be taken. Two sticky power-up outputs follow the NOP commands. The first NOP turns on the memory clock, and the next NOP raises the clock-enable pin.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: During and immediately after reset, mode_rd is 0, mem_valid, cmd_valid, mem_clk_en and mem_cke are 0, and issue_ready is 1.
- R2: A bus write with bus_reg=1 loads bus_mode_in into MODE at that clock edge. From then on, mode_rd shows the new value.
- R3: A memory-window access (bus_reg=0) that is a read in any mode, or a write while MODE=0, produces mem_valid=1 for one cycle on the following clock. mem_we and mem_addr carry the request's direction and address. A command-mode write never produces mem_valid.
- R4: A memory-window write accepted while MODE is 1, 3, 5 or 6 raises cmd_valid for exactly one cycle on the following clock. cmd_code is 0 (NOP) for MODE 1, 1 (mode-register load) for MODE 3, 2 (extended mode-register load) for MODE 5 and 3 (calibration) for MODE 6.
- R5: With wide32=0, cmd_ba equals bus_addr[27:25] of the trigger write. With wide32=1, cmd_ba equals bus_addr[28:26].
- R6: With wide32=0, cmd_a equals bus_addr[14:1] of the trigger write. With wide32=1, cmd_a equals bus_addr[15:2].
- R7: issue_ready is 0 from the cycle in which cmd_valid is high, and stays 0 for CMD_GAP (4) cycles. A command-mode window write presented while issue_ready is 0 issues nothing.
- R8: mem_clk_en rises together with the cmd_valid of the first NOP after reset. mem_cke rises together with the cmd_valid of the second NOP. Both then stay high until reset, and non-NOP commands leave them unchanged.
- R9: With MODE set to 2, 4 or 7, a window write issues no command, forwards no access and leaves issue_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | 1 = mode register, 0 = memory window |
| bus_addr | input | ADDR_W | Byte address in the memory window |
| bus_mode_in | input | 3 | MODE value for a mode register write |
| wide32 | input | 1 | Bus width: 0 = 16-bit, 1 = 32-bit |
| mode_rd | output | 3 | Current MODE value (register read data) |
| issue_ready | output | 1 | A new command trigger can be accepted |
| mem_valid | output | 1 | Forwarded data access strobe |
| mem_we | output | 1 | Direction of the forwarded access |
| mem_addr | output | ADDR_W | Address of the forwarded access |
| cmd_valid | output | 1 | Command strobe to the SDRAM command port |
| cmd_code | output | 2 | Command kind: 0 NOP, 1 MRS, 2 EMRS, 3 CAL |
| cmd_ba | output | BA_W | Bank address of the command |
| cmd_a | output | ROW_W | Payload for the address pins |
| mem_clk_en | output | 1 | Memory clock enable (first NOP) |
| mem_cke | output | 1 | CKE drive (second NOP) |

## Verification
Every command, forwarded access and power-up output is registered. Each is therefore due exactly one clock after the edge that samples the request. issue_ready and mode_rd come straight from state, so they are due after that same edge. The bench changes inputs on the falling edge, advances its reference model on the rising edge, and compares every output on the next falling edge, half a cycle after the values settle. Triggers sent into the gap, and triggers sent with unused MODE codes, are compared in the same way, because an issued command or forwarded access would appear one clock later.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_NORMAL = 3'd0;
  localparam logic [MODE_W-1:0] MODE_NOP    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_MRS    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_EMRS   = 3'd5;
  localparam logic [MODE_W-1:0] MODE_CAL    = 3'd6;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_MRS  = 2'd1,
    CMD_EMRS = 2'd2,
    CMD_CAL  = 2'd3
  } cmd_code_e;

  typedef struct packed {
    logic      valid;
    cmd_code_e code;
  } cmd_sel_t;

  function automatic cmd_sel_t decode_mode(input logic [MODE_W-1:0] mode);
    cmd_sel_t s;
    s.valid = 1'b1;
    s.code  = CMD_NOP;
    case (mode)
      MODE_NOP:  s.code = CMD_NOP;
      MODE_MRS:  s.code = CMD_MRS;
      MODE_EMRS: s.code = CMD_EMRS;
      MODE_CAL:  s.code = CMD_CAL;
      default:   s.valid = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CMD_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  localparam int GAP_W = $clog2(CMD_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_VAL = GAP_W'(CMD_GAP);

  logic [GAP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = GAP_VAL;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/sdram_cmd_builder.sv
module sdram_cmd_builder
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int BA_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  cmd_code_e        code,
  input  logic             wide32,
  input  logic [BA_W:0]    ba_field,
  input  logic [ROW_W:0]   row_field,
  output logic             cmd_valid,
  output cmd_code_e        cmd_code,
  output logic [BA_W-1:0]  cmd_ba,
  output logic [ROW_W-1:0] cmd_a,
  output logic             nop_fire
);
  logic [BA_W-1:0]  ba_sel;
  logic [ROW_W-1:0] a_sel;

  always_comb begin
    ba_sel = wide32 ? ba_field[BA_W:1]   : ba_field[BA_W-1:0];
    a_sel  = wide32 ? row_field[ROW_W:1] : row_field[ROW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_valid <= 1'b0;
    else        cmd_valid <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code <= CMD_NOP;
      cmd_ba   <= '0;
      cmd_a    <= '0;
    end else if (fire) begin
      cmd_code <= code;
      cmd_ba   <= ba_sel;
      cmd_a    <= a_sel;
    end
  end

  assign nop_fire = fire && (code == CMD_NOP);
endmodule

// File: rtl/sdram_power_seq.sv
module sdram_power_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic nop_fire,
  output logic clk_en,
  output logic cke
);
  logic clk_en_d, cke_d;

  always_comb begin
    clk_en_d = clk_en;
    cke_d    = cke;
    if (nop_fire) begin
      if (!clk_en) clk_en_d = 1'b1;
      else         cke_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en <= 1'b0;
      cke    <= 1'b0;
    end else begin
      clk_en <= clk_en_d;
      cke    <= cke_d;
    end
  end
endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ROW_W   = 14,
  parameter int BA_W    = 3,
  parameter int BA_LSB  = 25,
  parameter int CMD_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_reg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_mode_in,
  input  logic              wide32,
  output logic [2:0]        mode_rd,
  output logic              issue_ready,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ROW_W-1:0]  cmd_a,
  output logic              mem_clk_en,
  output logic              mem_cke
);
  logic [MODE_W-1:0] mode_q;
  cmd_sel_t          sel;
  cmd_code_e         code_q;
  logic              win_acc, mode_wr, fire, pass, nop_fire;

  always_comb begin
    win_acc = bus_req && !bus_reg;
    mode_wr = bus_req && bus_we && bus_reg;
    sel     = decode_mode(mode_q);
    fire    = win_acc && bus_we && sel.valid && issue_ready;
    pass    = win_acc && (!bus_we || (mode_q == MODE_NORMAL));
  end

  sdram_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr),
    .wr_data (bus_mode_in),
    .mode_q  (mode_q)
  );

  sdram_gap_timer #(.CMD_GAP(CMD_GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire),
    .ready (issue_ready)
  );

  sdram_cmd_builder #(.ROW_W(ROW_W), .BA_W(BA_W)) u_build (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .code      (sel.code),
    .wide32    (wide32),
    .ba_field  (bus_addr[BA_LSB+BA_W:BA_LSB]),
    .row_field (bus_addr[ROW_W+1:1]),
    .cmd_valid (cmd_valid),
    .cmd_code  (code_q),
    .cmd_ba    (cmd_ba),
    .cmd_a     (cmd_a),
    .nop_fire  (nop_fire)
  );

  sdram_power_seq u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .nop_fire (nop_fire),
    .clk_en   (mem_clk_en),
    .cke      (mem_cke)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_valid <= 1'b0;
    else        mem_valid <= pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else if (pass) begin
      mem_we   <= bus_we;
      mem_addr <= bus_addr;
    end
  end

  assign mode_rd  = mode_q;
  assign cmd_code = code_q;
endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic       bus_reg,
  input logic [2:0] bus_mode_in,
  input logic [2:0] mode_rd,
  input logic       issue_ready,
  input logic       mem_valid,
  input logic       mem_we,
  input logic       cmd_valid,
  input logic       mem_clk_en,
  input logic       mem_cke
);
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_reg) |=> (mode_rd == $past(bus_mode_in))); // R2
  AST_WRITE_PASS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> ($past(mode_rd) == 3'd0)); // R3
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R4
  AST_CMD_OR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && mem_valid)); // R4
  AST_BUSY_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !issue_ready); // R7
  AST_CMD_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(issue_ready)); // R7
  AST_CKE_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |-> mem_clk_en); // R8
  AST_CLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clk_en |=> mem_clk_en); // R8
  AST_CKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke); // R8
endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_reg     (bus_reg),
  .bus_mode_in (bus_mode_in),
  .mode_rd     (mode_rd),
  .issue_ready (issue_ready),
  .mem_valid   (mem_valid),
  .mem_we      (mem_we),
  .cmd_valid   (cmd_valid),
  .mem_clk_en  (mem_clk_en),
  .mem_cke     (mem_cke)
);

// File: tb/sdram_cmd_issuer_test.sv
`timescale 1ns/1ps
module sdram_cmd_issuer_test;
  localparam int ADDR_W = 32, ROW_W = 14, BA_W = 3, GAP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0, bus_reg = 1'b0, wide32 = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [2:0] bus_mode_in = '0;
  logic [2:0] mode_rd;
  logic issue_ready, mem_valid, mem_we, cmd_valid, mem_clk_en, mem_cke;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0] cmd_code;
  logic [BA_W-1:0] cmd_ba;
  logic [ROW_W-1:0] cmd_a;

  always #2 clk = ~clk;

  sdram_cmd_issuer uut (.*);

  int vectors = 0, errors = 0;
  int m_mode, m_gap, m_clk_en, m_cke, m_cv, m_code, m_ba, m_a, m_mv, m_mwe;
  longint m_maddr;
  bit in_reset = 1'b1;

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int mode_code(input int md);
    case (md)
      1: return 0;
      3: return 1;
      5: return 2;
      6: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic model_step();
    int c;
    m_cv = 0; m_mv = 0;
    if (!rst_n) begin
      m_mode = 0; m_gap = 0; m_clk_en = 0; m_cke = 0;
      return;
    end
    c = mode_code(m_mode);
    if (bus_req && !bus_reg && bus_we && c >= 0 && m_gap == 0) begin
      m_cv = 1; m_code = c;
      m_ba = int'((bus_addr >> (wide32 ? 26 : 25)) & 7);
      m_a  = int'((bus_addr >> (wide32 ? 2 : 1)) & ((1 << ROW_W) - 1));
      m_gap = GAP;
      if (c == 0) begin
        if (m_clk_en == 0) m_clk_en = 1; else m_cke = 1;
      end
    end else if (m_gap > 0) m_gap--;
    if (bus_req && !bus_reg && (!bus_we || m_mode == 0)) begin
      m_mv = 1; m_mwe = int'(bus_we); m_maddr = longint'(bus_addr);
    end
    if (bus_req && bus_we && bus_reg) m_mode = int'(bus_mode_in);
  endtask

  task automatic compare();
    chk(in_reset ? "R1 mode" : "R2 mode_rd", mode_rd, m_mode);
    chk(in_reset ? "R1 ready" : "R7 issue_ready", issue_ready, m_gap == 0);
    chk(in_reset ? "R1 mem_valid" : "R3 mem_valid", mem_valid, m_mv);
    if (m_mv) begin
      chk("R3 mem_we", mem_we, m_mwe);
      chk("R3 mem_addr", mem_addr, m_maddr);
    end
    chk(in_reset ? "R1 cmd_valid" : "R4 cmd_valid", cmd_valid, m_cv);
    if (m_cv) begin
      chk("R4 cmd_code", cmd_code, m_code);
      chk("R5 cmd_ba", cmd_ba, m_ba);
      chk("R6 cmd_a", cmd_a, m_a);
    end
    chk(in_reset ? "R1 clk_en" : "R8 mem_clk_en", mem_clk_en, m_clk_en);
    chk(in_reset ? "R1 cke" : "R8 mem_cke", mem_cke, m_cke);
  endtask

  task automatic cycle();
    @(posedge clk); model_step();
    @(negedge clk); compare();
  endtask

  task automatic access(input bit we, input bit rg, input logic [ADDR_W-1:0] a,
                        input logic [2:0] md);
    bus_req = 1'b1; bus_we = we; bus_reg = rg; bus_addr = a; bus_mode_in = md;
    cycle();
    bus_req = 1'b0; bus_we = 1'b0; bus_reg = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] md);
    access(1'b1, 1'b1, '0, md);
  endtask

  task automatic settle();
    for (int i = 0; i < GAP + 1; i++) cycle();
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle();
    rst_n = 1'b1;
    cycle();
    in_reset = 1'b0;
    // R3: normal-mode pass-through
    access(1'b1, 1'b0, 32'h0000_1234, 3'd0);
    access(1'b0, 1'b0, 32'h0ABC_0008, 3'd0);
    cycle();
    // R2, R4, R8: first NOP -> memory clock
    set_mode(3'd1);
    access(1'b1, 1'b0, 32'h0000_0040, 3'd0);
    // R7: trigger inside the gap is dropped
    access(1'b1, 1'b0, 32'h0000_0080, 3'd0);
    chk("R7 dropped trigger", cmd_valid, 0);
    cycle();
    chk("R7 no late command", cmd_valid, 0);
    settle();
    // R8: second NOP -> CKE
    access(1'b1, 1'b0, 32'h0000_0000, 3'd0);
    settle();
    // R5, R6: 16-bit bus
    wide32 = 1'b0;
    set_mode(3'd5);
    access(1'b1, 1'b0, (32'd2 << 25) | 32'h0000_5A5A, 3'd0);
    settle();
    access(1'b1, 1'b0, (32'd3 << 25) | 32'h0000_7FFE, 3'd0);
    settle();
    set_mode(3'd3);
    access(1'b1, 1'b0, 32'h0000_0D42, 3'd0);
    settle();
    set_mode(3'd6);
    access(1'b1, 1'b0, (32'd7 << 25), 3'd0);
    settle();
    // R5, R6: 32-bit bus
    wide32 = 1'b1;
    set_mode(3'd5);
    access(1'b1, 1'b0, (32'd3 << 26) | 32'h0000_A5A4, 3'd0);
    settle();
    access(1'b1, 1'b0, (32'd1 << 26) | 32'h0000_FFFC, 3'd0);
    settle();
    // R8: a third NOP changes nothing
    set_mode(3'd1);
    access(1'b1, 1'b0, 32'h0000_0010, 3'd0);
    settle();
    // R3: a read in command mode is forwarded
    access(1'b0, 1'b0, 32'h0123_4560, 3'd0);
    // R9: unused codes
    for (int k = 0; k < 3; k++) begin
      set_mode(k == 0 ? 3'd2 : (k == 1 ? 3'd4 : 3'd7));
      access(1'b1, 1'b0, 32'h0600_0002, 3'd0);
      cycle();
      chk("R9 no command", cmd_valid, 0);
      chk("R9 no access", mem_valid, 0);
      chk("R9 ready kept", issue_ready, 1);
    end
    // R2, R3: back to normal
    set_mode(3'd0);
    access(1'b1, 1'b0, 32'h0FFF_FFFE, 3'd0);
    cycle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule